// File: doc/BRIEF.md
# Label-Domain Minimum Check Node

This block is the check-node functional unit of a finite-alphabet LDPC decoder built as an unrolled, fully parallel pipeline. Each of its `DC` edges carries a short signed quantizer label in sign-magnitude form. For every edge it returns an extrinsic reply. The reply's sign is the parity of the signs on all the other edges. Its magnitude is the smallest magnitude among those other edges. The same unit is instantiated unchanged in every iteration stage.

The datapath works on the labels themselves. Magnitudes are never scaled or offset, and no two's-complement form appears at either edge, so a reply magnitude is always one of the incoming magnitudes, copied bit for bit. Internally the unit finds the overall minimum, the edge that holds it and the runner-up. The runner-up goes back to the holder and the minimum goes to every other edge. When several edges share the minimum, the lowest-numbered one is taken as the holder. A parameter chooses the minimum-search structure: a linear chain or a balanced pairwise tree. Both give the same results. One register stage holds the replies, and a valid flag travels alongside them.

Top module: `lmin_check_node`

## Requirements
- R1: Edge k occupies bits [k*MSG_W +: MSG_W] of both `in_msg` and `out_msg`. Bit MSG_W-1 of a field is the sign (1 = negative) and the lower MSG_W-1 bits are an unsigned magnitude.
- R2: The sign in the reply on edge k is the XOR of the sign bits of every input edge other than k.
- R3: The magnitude in the reply on edge k is the smallest input magnitude among all edges other than k.
- R4: When the smallest magnitude occurs on two or more edges, every edge, including each edge that holds it, receives that smallest magnitude.
- R5: Magnitudes are not transformed. Zero and the largest code 2^(MSG_W-1)-1 come back unchanged. An input with magnitude zero and sign 1 still counts as negative in the sign parity.
- R6: Replies to an input sampled with `in_valid` high appear on `out_msg` one clock later. `out_valid` equals `in_valid` delayed by one clock.
- R7: While `in_valid` is low, `out_msg` keeps its previous value whatever `in_msg` carries.
- R8: A synchronous active-high `rst` clears `out_msg` and `out_valid` to zero on the next clock, even if `in_valid` is high.
- R9: The chain and tree minimum-search variants give identical replies for any DC of at least 2, including degrees that are not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_msg` as a message set to process |
| in_msg | input | DC*MSG_W | Incoming variable-to-check labels, edge 0 in the low bits |
| out_valid | output | 1 | Marks `out_msg` as fresh replies |
| out_msg | output | DC*MSG_W | Registered check-to-variable replies, edge 0 in the low bits |

## Verification
The assertions assume that `in_valid` and `in_msg` always hold known values and that reset is applied at the first clock. They also assume DC is at least 2. This guarantees that at least DC-1 replies carry the same smallest magnitude, and that the parity of the reply signs is fixed by the parity of the input signs. The stimulus drives every input at the falling edge from fully defined values and raises reset once more with valid high. Directed sets place the minimum first, last, duplicated and everywhere. They also use all-zero, all-maximum and negative-zero labels. Two instances of different degree, width and search variant then receive thousands of random sets with a random valid pattern.

// File: rtl/lmcn_pkg.sv
package lmcn_pkg;
   // selects the structure used to locate the two smallest magnitudes
   typedef enum logic {
      MINSRCH_CHAIN = 1'b0,
      MINSRCH_TREE  = 1'b1
   } minsrch_e;
endpackage

// File: rtl/lmcn_two_min.sv
module lmcn_two_min
   import lmcn_pkg::*;
#(
   parameter int       DC   = 6,
   parameter int       MW   = 3,
   parameter minsrch_e ARCH = MINSRCH_TREE,
   localparam int      IW   = $clog2(DC)
) (
   input  logic [DC*MW-1:0] mags,
   output logic [MW-1:0]    min1,
   output logic [MW-1:0]    min2,
   output logic [IW-1:0]    min1_idx
);
   localparam int LV = $clog2(DC);
   localparam int NP = 1 << LV;

   if (ARCH == MINSRCH_CHAIN) begin : g_chain
      always_comb begin
         logic [MW-1:0] cur;
         min1     = '1;
         min2     = '1;
         min1_idx = '0;
         for (int i = 0; i < DC; i++) begin
            cur = mags[i*MW +: MW];
            if (cur < min1) begin
               min2     = min1;
               min1     = cur;
               min1_idx = IW'(i);
            end else if (cur < min2) begin
               min2 = cur;
            end
         end
      end
   end else begin : g_tree
      for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
         localparam int CNT = NP >> lv;
         logic [MW-1:0] m1 [CNT];
         logic [MW-1:0] m2 [CNT];
         logic [IW-1:0] ix [CNT];
         for (genvar e = 0; e < CNT; e++) begin : g_e
            if (lv == 0) begin : g_leaf
               if (e < DC) begin : g_real
                  assign m1[e] = mags[e*MW +: MW];
               end else begin : g_pad
                  assign m1[e] = '1;
               end
               assign m2[e] = '1;
               assign ix[e] = IW'(e);
            end else begin : g_merge
               logic [MW-1:0] lm1, lm2, rm1, rm2;
               logic [IW-1:0] lix, rix;
               logic          take_r;
               assign lm1 = g_lv[lv-1].m1[2*e];
               assign lm2 = g_lv[lv-1].m2[2*e];
               assign lix = g_lv[lv-1].ix[2*e];
               assign rm1 = g_lv[lv-1].m1[2*e+1];
               assign rm2 = g_lv[lv-1].m2[2*e+1];
               assign rix = g_lv[lv-1].ix[2*e+1];
               // strict compare: equal values keep the lower-index side
               assign take_r = rm1 < lm1;
               assign m1[e]  = take_r ? rm1 : lm1;
               assign ix[e]  = take_r ? rix : lix;
               assign m2[e]  = take_r ? ((lm1 < rm2) ? lm1 : rm2)
                                      : ((rm1 < lm2) ? rm1 : lm2);
            end
         end
      end
      assign min1     = g_lv[LV].m1[0];
      assign min2     = g_lv[LV].m2[0];
      assign min1_idx = g_lv[LV].ix[0];
   end

   always_comb begin
      AST_MIN_ORDER: assert (min1 <= min2);            // R3
      AST_IDX_RANGE: assert (int'(min1_idx) < DC);     // R4
   end
endmodule

// File: rtl/lmcn_sign_par.sv
module lmcn_sign_par #(
   parameter int DC = 6
) (
   input  logic [DC-1:0] in_sgn,
   output logic [DC-1:0] ext_sgn
);
   logic all_par;
   assign all_par = ^in_sgn;
   // removing an edge's own sign from the total leaves the others' parity
   assign ext_sgn = in_sgn ^ {DC{all_par}};
endmodule

// File: rtl/lmcn_edge_sel.sv
module lmcn_edge_sel #(
   parameter int  DC    = 6,
   parameter int  MSG_W = 4,
   localparam int MW    = MSG_W - 1,
   localparam int IW    = $clog2(DC)
) (
   input  logic [MW-1:0]       min1,
   input  logic [MW-1:0]       min2,
   input  logic [IW-1:0]       min1_idx,
   input  logic [DC-1:0]       ext_sgn,
   output logic [DC*MSG_W-1:0] reply
);
   for (genvar k = 0; k < DC; k++) begin : g_edge
      logic holder;
      assign holder = (min1_idx == IW'(k));
      assign reply[k*MSG_W +: MSG_W] = {ext_sgn[k], holder ? min2 : min1};
   end
endmodule

// File: rtl/lmin_check_node.sv
module lmin_check_node
   import lmcn_pkg::*;
#(
   parameter int       DC    = 6,
   parameter int       MSG_W = 4,
   parameter minsrch_e ARCH  = MINSRCH_TREE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [DC*MSG_W-1:0] in_msg,
   output logic               out_valid,
   output logic [DC*MSG_W-1:0] out_msg
);
   localparam int MW      = MSG_W - 1;
   localparam int IW      = $clog2(DC);
   localparam bit DC_EVEN = (DC % 2) == 0;

   if (DC < 2) begin : g_bad_dc
      $error("lmin_check_node: DC must be at least 2");
   end
   if (MSG_W < 2 || MSG_W > 8) begin : g_bad_w
      $error("lmin_check_node: MSG_W must lie in 2..8");
   end

   logic [DC-1:0]       in_sgn, ext_sgn;
   logic [DC*MW-1:0]    in_mag;
   logic [MW-1:0]       min1, min2;
   logic [IW-1:0]       min1_idx;
   logic [DC*MSG_W-1:0] reply;

   for (genvar k = 0; k < DC; k++) begin : g_split
      assign in_sgn[k]           = in_msg[k*MSG_W + MW];
      assign in_mag[k*MW +: MW]  = in_msg[k*MSG_W +: MW];
   end

   lmcn_two_min #(.DC(DC), .MW(MW), .ARCH(ARCH)) u_two_min (
      .mags     (in_mag),
      .min1     (min1),
      .min2     (min2),
      .min1_idx (min1_idx)
   );

   lmcn_sign_par #(.DC(DC)) u_sign_par (
      .in_sgn  (in_sgn),
      .ext_sgn (ext_sgn)
   );

   lmcn_edge_sel #(.DC(DC), .MSG_W(MSG_W)) u_edge_sel (
      .min1     (min1),
      .min2     (min2),
      .min1_idx (min1_idx),
      .ext_sgn  (ext_sgn),
      .reply    (reply)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_msg   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_msg <= reply;
      end
   end

   // observation of the registered replies, used only by the checks below
   logic [DC-1:0] out_sgn;
   logic [MW-1:0] out_low;
   int            out_low_cnt;
   always_comb begin
      out_low     = '1;
      out_low_cnt = 0;
      for (int k = 0; k < DC; k++) begin
         out_sgn[k] = out_msg[k*MSG_W + MW];
         if (out_msg[k*MSG_W +: MW] < out_low) out_low = out_msg[k*MSG_W +: MW];
      end
      for (int k = 0; k < DC; k++) begin
         if (out_msg[k*MSG_W +: MW] == out_low) out_low_cnt++;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (out_valid == 1'b0 && out_msg == '0));                     // R8
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      !rst |=> out_valid == $past(in_valid));                            // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!rst && !in_valid) |=> $stable(out_msg));                         // R7
   AST_SIGN_PARITY: assert property (@(posedge clk) disable iff (rst)
      (!rst && in_valid) |=> (^out_sgn) == (DC_EVEN ? $past(^in_sgn) : 1'b0)); // R2
   AST_MIN_MAJORITY: assert property (@(posedge clk) disable iff (rst)
      !rst |-> out_low_cnt >= DC - 1);                                   // R3
endmodule

// File: tb/lmin_check_node_bench.sv
module lmin_check_node_bench;
   import lmcn_pkg::*;

   localparam int DCA = 6, WA = 4;
   localparam int DCB = 5, WB = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [DCA*WA-1:0] in_a = '0;
   logic [DCB*WB-1:0] in_b = '0;
   logic              ov_a, ov_b;
   logic [DCA*WA-1:0] om_a;
   logic [DCB*WB-1:0] om_b;

   lmin_check_node #(.DC(DCA), .MSG_W(WA), .ARCH(MINSRCH_TREE)) u_lmin_check_node (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_a),
      .out_valid(ov_a), .out_msg(om_a));

   lmin_check_node #(.DC(DCB), .MSG_W(WB), .ARCH(MINSRCH_CHAIN)) u_lmin_check_node_alt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_b),
      .out_valid(ov_b), .out_msg(om_b));

   int    n_chk = 0, n_bad = 0;
   bit    armed = 1'b0, done = 1'b0;
   string pend_tag = "R8";
   logic              xv_a = 1'b0, xv_b = 1'b0;
   logic [DCA*WA-1:0] xm_a = '0;
   logic [DCB*WB-1:0] xm_b = '0;

   // behavioural reference: extrinsic sign parity and extrinsic minimum (R1, R2, R3)
   function automatic logic [63:0] ref_cn(input logic [63:0] v, input int dc, input int w);
      logic [63:0] r;
      int mm;
      r  = '0;
      mm = (1 << (w - 1)) - 1;
      for (int k = 0; k < dc; k++) begin
         int s, best;
         s = 0;
         best = 1 << 20;
         for (int j = 0; j < dc; j++) begin
            if (j != k) begin
               int mag;
               mag = int'(v >> (j * w)) & mm;
               s ^= int'(v[j*w + w - 1]);
               if (mag < best) best = mag;
            end
         end
         r |= 64'((s << (w - 1)) | best) << (k * w);
      end
      return r;
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: compare against the expectation for the edge just passed, then drive
   task automatic tick(input logic r, input logic v, input logic [DCA*WA-1:0] a,
                       input logic [DCB*WB-1:0] b, input string tag);
      @(negedge clk);
      if (armed) begin
         check(pend_tag == "R8" ? "R8" : "R6", "valid A", 64'(ov_a), 64'(xv_a));
         check(pend_tag == "R8" ? "R8" : "R6", "valid B", 64'(ov_b), 64'(xv_b));
         check(pend_tag, "data A", 64'(om_a), 64'(xm_a));
         check(pend_tag, "data B", 64'(om_b), 64'(xm_b));
      end
      armed    = 1'b1;
      pend_tag = tag;
      rst      = r;
      in_valid = v;
      in_a     = a;
      in_b     = b;
      if (r) begin
         xv_a = 1'b0; xv_b = 1'b0; xm_a = '0; xm_b = '0;
      end else begin
         xv_a = v; xv_b = v;
         if (v) begin
            xm_a = (DCA*WA)'(ref_cn(64'(a), DCA, WA));
            xm_b = (DCB*WB)'(ref_cn(64'(b), DCB, WB));
         end
      end
   endtask

   // packs one label per edge for both instances, magnitude clipped to each width (R1)
   task automatic drive_set(input int mags[8], input logic [7:0] sg, input string tag);
      logic [DCA*WA-1:0] a;
      logic [DCB*WB-1:0] b;
      a = '0;
      b = '0;
      for (int k = 0; k < DCA; k++)
         a[k*WA +: WA] = {sg[k], 3'(mags[k] & 7)};
      for (int k = 0; k < DCB; k++)
         b[k*WB +: WB] = {sg[k], 2'(mags[k] & 3)};
      tick(1'b0, 1'b1, a, b, tag);
   endtask

   initial begin
      // R8: reset held with valid high and live data
      tick(1'b1, 1'b1, '1, '1, "R8");
      tick(1'b1, 1'b1, 24'h5A5A5A, 15'h2B3C, "R8");
      tick(1'b0, 1'b0, '0, '0, "R8");
      tick(1'b0, 1'b0, '0, '0, "R8");
      // R3: unique minimum on edge 0, then on the last edge
      drive_set('{1, 2, 3, 4, 5, 6, 7, 7}, 8'h00, "R3");
      drive_set('{7, 6, 5, 4, 3, 2, 1, 1}, 8'h00, "R3");
      drive_set('{6, 5, 4, 3, 2, 7, 7, 7}, 8'h00, "R3");
      // R4: shared minimum, and all edges equal
      drive_set('{3, 1, 5, 1, 6, 7, 0, 0}, 8'h12, "R4");
      drive_set('{2, 2, 2, 2, 2, 2, 2, 2}, 8'h3F, "R4");
      drive_set('{0, 3, 0, 3, 2, 0, 0, 0}, 8'h00, "R4");
      // R5: extreme magnitudes and negative zero
      drive_set('{7, 7, 7, 7, 7, 7, 7, 7}, 8'h00, "R5");
      drive_set('{0, 0, 0, 0, 0, 0, 0, 0}, 8'h2D, "R5");
      drive_set('{7, 0, 7, 7, 3, 7, 0, 0}, 8'h02, "R5");
      // R2: sign parity patterns
      drive_set('{4, 5, 6, 7, 1, 2, 0, 0}, 8'hA5, "R2");
      drive_set('{4, 5, 6, 7, 1, 2, 0, 0}, 8'h01, "R2");
      drive_set('{4, 5, 6, 7, 1, 2, 0, 0}, 8'h1F, "R2");
      // R7: valid low while data keeps changing; R6 valid drops with it
      for (int i = 0; i < 6; i++)
         tick(1'b0, 1'b0, (DCA*WA)'($urandom), (DCB*WB)'($urandom), "R7");
      drive_set('{5, 3, 6, 3, 7, 4, 0, 0}, 8'h09, "R6");
      tick(1'b0, 1'b0, '1, '1, "R7");
      // R8: reset in the middle of traffic
      tick(1'b1, 1'b1, 24'h123456, 15'h1234, "R8");
      tick(1'b0, 1'b0, '0, '0, "R8");
      // R9: both search variants against the same reference under random traffic
      for (int i = 0; i < 3000; i++)
         tick(1'b0, 1'($urandom_range(0, 3) != 0),
              (DCA*WA)'($urandom), (DCB*WB)'($urandom), "R9");
      tick(1'b0, 1'b0, '0, '0, "R9");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule